// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Scheduler

This block decides, once per clock cycle, which inputs of an N-by-N input-queued crossbar may send a cell to which outputs. Every input keeps one queue per output. The caller presents a request matrix in which bit `i*N + j` is set when input `i` has a cell waiting for output `j`. The scheduler runs request, grant and accept phases. A grant pointer at each output and an accept pointer at each input break ties in round-robin order. The result is a pairing in which no input and no output appears twice.

Several grant/accept iterations are chained within the same cycle. Each later iteration works only on the inputs and outputs that are still free. The pointers learn only from the first iteration. A grant pointer moves only when its grant is taken, so the output arbiters drift apart from each other. Under steady full load this gives a complete matching in every slot. The matching is registered and appears one cycle after the request matrix that produced it.

Top module: `xbar_rr_sched`

## Requirements
- R1: Input `i` takes part for output `j` exactly when request bit `i*N + j` is set. A match bit `i*N + j` of `match_oh_o` is only ever set if the same request bit was set in the previous cycle.
- R2: Each output grants the first requesting input found by searching upward, with wrap-around, from its grant pointer.
- R3: Each input accepts the first granting output found by searching upward, with wrap-around, from its accept pointer.
- R4: When an output's grant is accepted in the first iteration, its grant pointer becomes the granted input plus one, modulo N. A grant that is not accepted leaves that pointer unchanged.
- R5: An input's accept pointer becomes the accepted output plus one, modulo N, after a first-iteration accept.
- R6: In every cycle, each N-bit row of `match_oh_o` (one input) and each column (one output) holds at most one set bit.
- R7: The matching for the request matrix present in a cycle appears on `match_oh_o` in the next cycle. `match_vld_o[i]` is set exactly when row `i` holds a set bit.
- R8: Iterations after the first consider only inputs and outputs left unmatched by earlier iterations. With all requests set from reset and two iterations, the first slot matches input 0 to output 0 and input 1 to output 1.
- R9: While `rst_n` is low, all pointers are zero and both outputs are zero. Release of reset takes effect on the second rising clock edge after `rst_n` rises.
- R10: When two inputs keep requesting only the same output, that output serves them in turn.
- R11: With every request bit held set from reset (N=4, two iterations), every input is matched in every slot from the third slot onward.
- R12: Any cycle with at least one request bit set produces at least one match in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | N*N | Request matrix; bit i*N+j set when input i holds a cell for output j |
| match_oh_o | output | N*N | Registered matching; row i (bits i*N..i*N+N-1) is one-hot on the output given to input i |
| match_vld_o | output | N | Registered flag per input, set when that input received an output |

## Verification
A lone request shows the one-cycle registered path and the deassertion that follows. Two inputs contending for one output show the rotation of the grant pointer. One input asking for two outputs shows the rotation of the accept pointer and, in a follow-up slot, that a refused grant leaves the output's pointer where it was. An all-ones matrix from reset has exact expected matchings for the first three slots, which separate the effect of the second iteration from the pointer updates. After that, every input must be matched in every slot. A long pseudo-random sequence of sparse and dense matrices checks every slot for conflicts, for matches without a request, and for an empty result despite pending requests.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;

  // Position following idx on a ring of n ports.
  function automatic int rr_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction

  // Width needed to hold a port index for n ports.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_pick.sv
// Round-robin selector: first set bit at or after ptr, wrapping.
module rr_pick #(
  parameter int N  = 4,
  parameter int PW = rr_sched_pkg::idx_width(N)
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);

  logic found;
  int   idx;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/isl_stage.sv
// One grant/accept iteration over the ports that are still free.
module isl_stage #(
  parameter int N  = 4,
  parameter int PW = rr_sched_pkg::idx_width(N),
  localparam int NN = N * N
) (
  input  logic [NN-1:0]   req_i,
  input  logic [N-1:0]    in_free_i,
  input  logic [N-1:0]    out_free_i,
  input  logic [N*PW-1:0] gptr_i,
  input  logic [N*PW-1:0] aptr_i,
  output logic [NN-1:0]   match_o,
  output logic [N-1:0]    in_take_o,
  output logic [N-1:0]    out_take_o
);

  logic [NN-1:0] gnt_bits;

  // Grant phase: one arbiter per output, scanning inputs.
  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0] col_req;
    logic [N-1:0] col_gnt;
    for (genvar i = 0; i < N; i++) begin : g_col
      assign col_req[i]         = req_i[i*N + j] & in_free_i[i] & out_free_i[j];
      assign gnt_bits[i*N + j]  = col_gnt[i];
    end
    rr_pick #(.N(N), .PW(PW)) u_grant (
      .req (col_req),
      .ptr (gptr_i[j*PW +: PW]),
      .gnt (col_gnt)
    );
  end

  // Accept phase: one arbiter per input, scanning the grants it received.
  for (genvar i = 0; i < N; i++) begin : g_in
    rr_pick #(.N(N), .PW(PW)) u_accept (
      .req (gnt_bits[i*N +: N]),
      .ptr (aptr_i[i*PW +: PW]),
      .gnt (match_o[i*N +: N])
    );
    assign in_take_o[i] = |match_o[i*N +: N];
  end

  always_comb begin
    out_take_o = '0;
    for (int i = 0; i < N; i++) begin
      out_take_o = out_take_o | match_o[i*N +: N];
    end
  end

endmodule

// File: rtl/xbar_rr_sched.sv
module xbar_rr_sched #(
  parameter int N     = 4,
  parameter int ITERS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*N-1:0]   req_i,
  output logic [N*N-1:0]   match_oh_o,
  output logic [N-1:0]     match_vld_o
);
  import rr_sched_pkg::*;

  localparam int PW = idx_width(N);
  localparam int NN = N * N;

  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // ---------------- pointer state ----------------
  logic [N*PW-1:0] gptr_q, gptr_d;
  logic [N*PW-1:0] aptr_q, aptr_d;
  logic            ptr_en;

  // ---------------- iteration chain ----------------
  logic [N-1:0]  in_free  [ITERS+1];
  logic [N-1:0]  out_free [ITERS+1];
  logic [NN-1:0] stage_match [ITERS];
  logic [N-1:0]  stage_in_take  [ITERS];
  logic [N-1:0]  stage_out_take [ITERS];

  assign in_free[0]  = '1;
  assign out_free[0] = '1;

  for (genvar k = 0; k < ITERS; k++) begin : g_iter
    isl_stage #(.N(N), .PW(PW)) u_stage (
      .req_i      (req_i),
      .in_free_i  (in_free[k]),
      .out_free_i (out_free[k]),
      .gptr_i     (gptr_q),
      .aptr_i     (aptr_q),
      .match_o    (stage_match[k]),
      .in_take_o  (stage_in_take[k]),
      .out_take_o (stage_out_take[k])
    );
    assign in_free[k+1]  = in_free[k]  & ~stage_in_take[k];
    assign out_free[k+1] = out_free[k] & ~stage_out_take[k];
  end

  // ---------------- next state ----------------
  logic [NN-1:0] match_d;
  logic [N-1:0]  vld_d;

  always_comb begin
    match_d = '0;
    for (int k = 0; k < ITERS; k++) begin
      match_d = match_d | stage_match[k];
    end
    for (int i = 0; i < N; i++) begin
      vld_d[i] = |match_d[i*N +: N];
    end
  end

  // Pointers learn only from first-iteration matches.
  always_comb begin
    gptr_d = gptr_q;
    aptr_d = aptr_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (stage_match[0][i*N + j]) begin
          gptr_d[j*PW +: PW] = PW'(rr_next(i, N));
          aptr_d[i*PW +: PW] = PW'(rr_next(j, N));
        end
      end
    end
  end
  assign ptr_en = |stage_match[0];

  // ---------------- registers ----------------
  logic [NN-1:0] match_q;
  logic [N-1:0]  vld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gptr_q <= '0;
      aptr_q <= '0;
    end else if (ptr_en) begin
      gptr_q <= gptr_d;
      aptr_q <= aptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      match_q <= '0;
      vld_q   <= '0;
    end else begin
      match_q <= match_d;
      vld_q   <= vld_d;
    end
  end

  assign match_oh_o  = match_q;
  assign match_vld_o = vld_q;

  // ---------------- assertions ----------------
  // R1
  match_has_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((match_oh_o & ~$past(req_i)) == '0));

  // R12
  req_gives_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|req_i) |=> (|match_vld_o));

  for (genvar i = 0; i < N; i++) begin : g_row_chk
    // R6
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $onehot0(match_oh_o[i*N +: N]));
    // R7
    vld_row_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      match_vld_o[i] == (|match_oh_o[i*N +: N]));
  end

  for (genvar j = 0; j < N; j++) begin : g_col_chk
    logic [N-1:0] col;
    always_comb begin
      for (int i = 0; i < N; i++) col[i] = match_q[i*N + j];
    end
    // R6
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $onehot0(col));
  end

endmodule

// File: tb/xbar_rr_sched_bench.sv
`timescale 1ns/1ps
module xbar_rr_sched_bench;
  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk;
  logic          rst_n;
  logic [NN-1:0] req;
  logic [NN-1:0] match_oh;
  logic [N-1:0]  match_vld;

  int checks = 0;
  int fails  = 0;

  xbar_rr_sched #(.N(N), .ITERS(2)) u_xbar_rr_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .match_oh_o  (match_oh),
    .match_vld_o (match_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [NN-1:0] bit_at(input int i, input int j);
    logic [NN-1:0] v;
    v = '0;
    v[i*N + j] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_vld(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Legality of the current outputs against the request r of the previous slot.
  task automatic chk_legal(input string tag, input logic [NN-1:0] r);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      if ($countones(match_oh[i*N +: N]) > 1) ok = 1'b0;       // R6 rows
      if (match_vld[i] !== (|match_oh[i*N +: N])) ok = 1'b0;   // R7
    end
    for (int j = 0; j < N; j++) begin
      int c;
      c = 0;
      for (int i = 0; i < N; i++) c += int'(match_oh[i*N + j]);
      if (c > 1) ok = 1'b0;                                    // R6 columns
    end
    if ((match_oh & ~r) != '0) ok = 1'b0;                      // R1
    if ((|r) && !(|match_vld)) ok = 1'b0;                      // R12
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s R1/R6/R7/R12: actual match %h vld %b, expected legal matching of req %h",
               tag, match_oh, match_vld, r);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req   = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Drive a request matrix; on return outputs show its matching.
  task automatic slot(input logic [NN-1:0] r);
    req = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = '1;
    @(negedge clk);
    chk("R9 reset match", match_oh, '0);
    chk_vld("R9 reset vld", match_vld, '0);
    req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle after release", match_oh, '0);
  endtask

  task automatic t_single();
    do_reset();
    slot(bit_at(2, 3));
    chk("R1 R7 single request", match_oh, bit_at(2, 3));
    chk_vld("R7 single vld", match_vld, 4'b0100);
    slot('0);
    chk("R7 cleared next slot", match_oh, '0);
  endtask

  task automatic t_alternate();
    logic [NN-1:0] r;
    do_reset();
    r = bit_at(0, 0) | bit_at(1, 0);
    for (int s = 0; s < 6; s++) begin
      slot(r);
      chk("R2 R4 R10 alternation", match_oh, (s % 2 == 0) ? bit_at(0, 0) : bit_at(1, 0));
    end
  endtask

  task automatic t_accept_ptr();
    logic [NN-1:0] r;
    do_reset();
    r = bit_at(0, 0) | bit_at(0, 1);
    slot(r);
    chk("R3 first accept", match_oh, bit_at(0, 0));
    slot(r);
    chk("R5 accept pointer advanced", match_oh, bit_at(0, 1));
    slot(r);
    chk("R5 accept pointer wraps", match_oh, bit_at(0, 0));
  endtask

  task automatic t_unaccepted();
    do_reset();
    slot(bit_at(0, 0) | bit_at(0, 1));
    chk("R4 slot1", match_oh, bit_at(0, 0));
    slot(bit_at(0, 1) | bit_at(1, 1));
    chk("R4 refused grant kept pointer", match_oh, bit_at(0, 1));
  endtask

  task automatic t_full();
    do_reset();
    slot('1);
    chk("R8 second iteration slot1", match_oh, bit_at(0, 0) | bit_at(1, 1));
    slot('1);
    chk("R8 slot2", match_oh, bit_at(0, 1) | bit_at(1, 0) | bit_at(2, 2));
    slot('1);
    chk("R11 slot3", match_oh, bit_at(0, 2) | bit_at(1, 1) | bit_at(2, 0) | bit_at(3, 3));
    for (int s = 0; s < 12; s++) begin
      slot('1);
      chk_vld("R11 full throughput", match_vld, '1);
      chk_legal("R11 full legal", '1);
    end
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    logic [NN-1:0] r;
    do_reset();
    lfsr = 16'hACE1;
    for (int s = 0; s < 300; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = NN'(lfsr);
      if (s % 3 == 0) r = r & NN'(lfsr >> 3);
      if (s % 17 == 0) r = '0;
      slot(r);
      chk_legal("R6 random", r);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req   = '0;
    t_reset();
    t_single();
    t_alternate();
    t_accept_ptr();
    t_unaccepted();
    t_full();
    t_random();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule